// File: doc/BRIEF.md
# Sector Erase Window and Suspend Controller

This block runs the sector-erase phase of a NOR flash array. A decoded sector-erase command opens an acceptance window. Each further sector-erase command received inside that window adds its sector to the selection and starts the window again. When the window lapses, the unprotected sectors in the selection are erased one after another, lowest index first. A fixed tick count per sector stands in for the real cell erase. The host can pause the operation with a suspend command and continue it with a resume command. While the operation runs, the block also builds the status byte that reads return.

The inputs are one-cycle command events carrying a kind code and a sector number, read strobes carrying the sector number of the read address, a per-sector protect mask and a one-microsecond tick. The outputs are the status byte, a flag that says whether a read must return that status byte or array data, and busy and suspended flags. All durations are parameters counted in ticks: the window, the erase time per sector, the overall erase limit, the worst-case suspend latency and the busy time shown when nothing can be erased.

Top module: `sector_erase_ctrl`

## Requirements
- R1: Command kind codes: 0 is other (which includes the reset command), 1 is sector erase, 2 is suspend and 3 is resume. In idle, a sector-erase command opens the window and selects its sector. Every sector-erase command inside the window adds its sector and restarts the window. Erasing begins on the WINDOW_TICKS-th tick after the last accepted sector-erase command.
- R2: A command of kind other or resume that arrives while the window is open clears the selection and returns the block to idle (busy=0), with no erase.
- R3: A suspend that arrives while the window is open raises suspended in the next cycle. A later resume starts the erase.
- R4: A suspend that arrives during the erase raises suspended when the sector in progress completes or after SUSP_TICKS ticks, whichever comes first. The erase progress is kept across the suspension.
- R5: A resume that arrives while suspended clears suspended and continues the erase. A resume that arrives while not suspended has no effect. A suspend issued after a resume is accepted again.
- R6: Status bit 3 is 0 while the window is open and 1 in every other busy state. When idle, the whole status byte is 0.
- R7: Status bit 7 is 1 while suspended and 0 in the window, erase, all-protected and failed states.
- R8: Status bit 6 inverts after every read strobe in the window, erase, all-protected and failed states. It holds steady while suspended.
- R9: Status bit 2 inverts after each read of a selected sector in the erase and suspended states. Reads of other sectors leave it unchanged.
- R10: status_sel is 1 in every busy state except suspended. While suspended, it is 1 only for reads of a selected sector, so that reads of other sectors return array data.
- R11: Protected sectors in the selection are skipped, so the erase lasts ERASE_TICKS ticks for each unprotected selected sector. If every selected sector is protected, busy stays high for ALLPROT_TICKS ticks after the window closes and the block then returns to idle.
- R12: If LIMIT_TICKS erase ticks pass before the erase completes, the block enters a failed state with status bit 5 at 1 and busy at 1. It leaves that state only on a command of kind other.
- R13: Commands of kind other and sector-erase commands are ignored during the erase, the suspended state and the all-protected state. Sectors named in such ignored sector-erase commands are not added to the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command event |
| cmd_kind | input | 2 | Command kind code (see R1) |
| cmd_sector | input | SECT_W | Sector number of the command address |
| rd_strobe | input | 1 | One-cycle read event |
| rd_sector | input | SECT_W | Sector number of the read address |
| prot_mask | input | N_SECT | Per-sector protect bits |
| tick_us | input | 1 | One-cycle microsecond tick |
| status | output | 8 | Status byte for the current read |
| status_sel | output | 1 | 1 when a read must return status, 0 when it returns array data |
| busy | output | 1 | Operation pending (any state other than idle) |
| suspended | output | 1 | Erase suspended |

## Verification
On every cycle, the assertions check the main state transitions: aborting the window, an immediate suspend from the window, the suspend-latency bound, resume, holding the failed state, the per-sector reduction of the work mask, the erase limit counter, and the toggle behaviour of bits 6 and 2. Only the bench scenarios can show end-to-end timing. These include the exact tick on which a restarted window closes, total erase time as a function of the selection and protect masks, the busy period when every selected sector is protected, and the point at which the erase limit fires. The scenarios also show that erase progress survives a suspension and that an ignored sector-erase command leaves its sector unselected.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WIN, ST_ERASE, ST_SUSP, ST_ALLPROT, ST_FAIL
  } ctrl_state_t;

  typedef enum logic [1:0] {
    CMD_OTHER   = 2'd0,
    CMD_SERASE  = 2'd1,
    CMD_SUSPEND = 2'd2,
    CMD_RESUME  = 2'd3
  } cmd_kind_t;

  localparam int BIT_POLL     = 7;
  localparam int BIT_TOGGLE   = 6;
  localparam int BIT_LIMIT    = 5;
  localparam int BIT_PHASE    = 3;
  localparam int BIT_SECT_TOG = 2;

  function automatic logic [7:0] pack_status(input logic poll, input logic tog,
                                             input logic lim, input logic phase,
                                             input logic stog);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_POLL]     = poll;
    b[BIT_TOGGLE]   = tog;
    b[BIT_LIMIT]    = lim;
    b[BIT_PHASE]    = phase;
    b[BIT_SECT_TOG] = stog;
    return b;
  endfunction

endpackage

// File: rtl/sec_tick_timer.sv
module sec_tick_timer #(
  parameter int LIMIT_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT_TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == CW'(LIMIT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart)               cnt_q <= '0;
    else if (run && tick && !expire) cnt_q <= cnt_q + 1'b1;
  end

  assert_timer_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < CW'(LIMIT_TICKS));

endmodule

// File: rtl/sec_erase_engine.sv
module sec_erase_engine #(
  parameter int N_SECT      = 32,
  parameter int ERASE_TICKS = 10,
  parameter int LIMIT_TICKS = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_SECT-1:0] work_in,
  input  logic              run,
  input  logic              tick,
  output logic              seg_done,
  output logic              all_done,
  output logic              overtime
);
  localparam int SEG_W = $clog2(ERASE_TICKS + 1);
  localparam int TOT_W = $clog2(LIMIT_TICKS + 1);

  logic [N_SECT-1:0] work_q, head, rest;
  logic [SEG_W-1:0]  seg_q;
  logic [TOT_W-1:0]  tot_q;

  // lowest set bit of the remaining work: the sector now being erased
  function automatic logic [N_SECT-1:0] lowest_bit(input logic [N_SECT-1:0] m);
    return m & (~m + {{(N_SECT-1){1'b0}}, 1'b1});
  endfunction

  assign head     = lowest_bit(work_q);
  assign rest     = work_q & ~head;
  assign seg_done = run && tick && (seg_q == SEG_W'(ERASE_TICKS - 1));
  assign all_done = seg_done && (rest == '0);
  assign overtime = run && tick && !all_done && (tot_q == TOT_W'(LIMIT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      seg_q  <= '0;
      tot_q  <= '0;
    end else if (load) begin
      work_q <= work_in;
      seg_q  <= '0;
      tot_q  <= '0;
    end else if (run && tick) begin
      tot_q <= tot_q + 1'b1;
      if (seg_done) begin
        seg_q  <= '0;
        work_q <= rest;
      end else begin
        seg_q <= seg_q + 1'b1;
      end
    end
  end

  assert_limit_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tot_q < TOT_W'(LIMIT_TICKS));

  assert_one_sector_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_done && !load) |=> $countones(work_q) == $countones($past(work_q)) - 1);

endmodule

// File: rtl/sec_status_gen.sv
module sec_status_gen
  import sec_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       in_window,
  input  logic       tog_en,
  input  logic       sect_en,
  input  logic       susp,
  input  logic       failed,
  input  logic       rd_strobe,
  input  logic       rd_hit,
  output logic [7:0] status
);
  logic t6_q, t2_q;
  logic flip6, flip2;

  assign flip6 = rd_strobe && tog_en;
  assign flip2 = rd_strobe && sect_en && rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (!active) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      if (flip6) t6_q <= ~t6_q;
      if (flip2) t2_q <= ~t2_q;
    end
  end

  assign status = active ? pack_status(susp, t6_q, failed, !in_window, t2_q) : 8'h00;

  assert_tog6_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && tog_en) |=> t6_q != $past(t6_q));

  assert_tog6_still_susp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && active) |=> $stable(t6_q) || !active);

  assert_tog2_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(rd_strobe && rd_hit)) |=> $stable(t2_q) || !active);

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sec_erase_pkg::*;
#(
  parameter int N_SECT        = 32,
  parameter int WINDOW_TICKS  = 50,
  parameter int ERASE_TICKS   = 10,
  parameter int LIMIT_TICKS   = 45,
  parameter int SUSP_TICKS    = 20,
  parameter int ALLPROT_TICKS = 100,
  localparam int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              rd_strobe,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [N_SECT-1:0] prot_mask,
  input  logic              tick_us,
  output logic [7:0]        status,
  output logic              status_sel,
  output logic              busy,
  output logic              suspended
);
  ctrl_state_t       state_q, state_d;
  logic [N_SECT-1:0] sel_q, sel_d, live_sel;
  logic              started_q, pend_q;

  // named internal events
  logic is_serase, is_susp, is_resume, is_other;
  logic launch, go_allprot, eng_load, accept_susp;
  logic win_expire, ap_expire, sp_expire;
  logic seg_done, all_done, overtime;
  logic rd_hit, none_live;

  function automatic logic [N_SECT-1:0] sect_bit(input logic [SECT_W-1:0] idx);
    return {{(N_SECT-1){1'b0}}, 1'b1} << idx;
  endfunction

  assign is_serase = cmd_valid && (cmd_kind == CMD_SERASE);
  assign is_susp   = cmd_valid && (cmd_kind == CMD_SUSPEND);
  assign is_resume = cmd_valid && (cmd_kind == CMD_RESUME);
  assign is_other  = cmd_valid && (cmd_kind == CMD_OTHER);

  assign live_sel   = sel_q & ~prot_mask;
  assign none_live  = (live_sel == '0);
  assign go_allprot = launch && none_live;
  assign eng_load   = launch && !none_live;
  assign rd_hit     = sel_q[rd_sector];

  sec_tick_timer #(.LIMIT_TICKS(WINDOW_TICKS)) win_tmr_i (
    .clk(clk), .rst_n(rst_n),
    .restart(is_serase && (state_q == ST_IDLE || state_q == ST_WIN)),
    .run(state_q == ST_WIN), .tick(tick_us), .expire(win_expire));

  sec_tick_timer #(.LIMIT_TICKS(ALLPROT_TICKS)) ap_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(go_allprot),
    .run(state_q == ST_ALLPROT), .tick(tick_us), .expire(ap_expire));

  sec_tick_timer #(.LIMIT_TICKS(SUSP_TICKS)) sp_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(accept_susp),
    .run(pend_q), .tick(tick_us), .expire(sp_expire));

  sec_erase_engine #(.N_SECT(N_SECT), .ERASE_TICKS(ERASE_TICKS),
                     .LIMIT_TICKS(LIMIT_TICKS)) engine_i (
    .clk(clk), .rst_n(rst_n), .load(eng_load), .work_in(live_sel),
    .run(state_q == ST_ERASE), .tick(tick_us),
    .seg_done(seg_done), .all_done(all_done), .overtime(overtime));

  always_comb begin
    state_d     = state_q;
    sel_d       = sel_q;
    launch      = 1'b0;
    accept_susp = 1'b0;
    unique case (state_q)
      ST_IDLE: if (is_serase) begin
        sel_d   = sect_bit(cmd_sector);
        state_d = ST_WIN;
      end
      ST_WIN: begin
        if (is_serase)      sel_d = sel_q | sect_bit(cmd_sector);
        else if (is_susp)   state_d = ST_SUSP;
        else if (cmd_valid) state_d = ST_IDLE;
        else if (win_expire) launch = 1'b1;
      end
      ST_ERASE: begin
        if (all_done)       state_d = ST_IDLE;
        else if (overtime)  state_d = ST_FAIL;
        else if (pend_q && (seg_done || sp_expire)) state_d = ST_SUSP;
        else if (is_susp && !pend_q) accept_susp = 1'b1;
      end
      ST_SUSP: if (is_resume) begin
        if (started_q) state_d = ST_ERASE;
        else           launch  = 1'b1;
      end
      ST_ALLPROT: if (ap_expire) state_d = ST_IDLE;
      ST_FAIL:    if (is_other)  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (launch) state_d = none_live ? ST_ALLPROT : ST_ERASE;
    if (state_d == ST_IDLE) sel_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      started_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      if (eng_load)                  started_q <= 1'b1;
      else if (state_d == ST_IDLE)   started_q <= 1'b0;
      if (accept_susp)               pend_q <= 1'b1;
      else if (state_d != ST_ERASE)  pend_q <= 1'b0;
    end
  end

  sec_status_gen status_i (
    .clk(clk), .rst_n(rst_n),
    .active(state_q != ST_IDLE),
    .in_window(state_q == ST_WIN),
    .tog_en(state_q inside {ST_WIN, ST_ERASE, ST_ALLPROT, ST_FAIL}),
    .sect_en(state_q inside {ST_ERASE, ST_SUSP}),
    .susp(state_q == ST_SUSP),
    .failed(state_q == ST_FAIL),
    .rd_strobe(rd_strobe), .rd_hit(rd_hit), .status(status));

  assign busy       = (state_q != ST_IDLE);
  assign suspended  = (state_q == ST_SUSP);
  assign status_sel = busy && (!suspended || rd_hit);

  assert_win_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN && (is_other || is_resume)) |=> (state_q == ST_IDLE && sel_q == '0));

  assert_win_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN && is_susp) |=> suspended);

  assert_susp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && pend_q && sp_expire) |=> state_q != ST_ERASE);

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && is_resume) |=> (state_q == ST_ERASE || state_q == ST_ALLPROT));

  assert_fail_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL && !is_other) |=> state_q == ST_FAIL);

  assert_ignore_in_susp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !is_resume) |=> (suspended && $stable(sel_q)));

endmodule

// File: tb/sector_erase_ctrl_tb.sv
module sector_erase_ctrl_tb_top;
  localparam int N_SECT = 32;
  localparam int SW = 5;
  localparam int WIN = 50, ER = 10, LIM = 45, AP = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [SW-1:0] cmd_sector = '0;
  logic rd_strobe = 1'b0;
  logic [SW-1:0] rd_sector = '0;
  logic [N_SECT-1:0] prot_mask = '0;
  logic tick_us = 1'b0;
  logic [7:0] status;
  logic status_sel, busy, suspended;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sector_erase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .prot_mask(prot_mask), .tick_us(tick_us), .status(status),
    .status_sel(status_sel), .busy(busy), .suspended(suspended));

  // {selection mask, protect mask}
  localparam logic [63:0] VEC [5] = '{
    {32'h0000_0001, 32'h0000_0000},
    {32'h8001_0010, 32'h0000_0010},
    {32'h0000_0006, 32'h0000_0006},
    {32'h0000_001F, 32'h0000_0000},
    {32'h0000_00F0, 32'h0000_0080}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input int sec);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_sector = SW'(sec);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
    end
  endtask

  task automatic rd(input int sec, output logic [7:0] val, output logic ssel);
    @(negedge clk);
    rd_sector = SW'(sec);
    #1;
    val = status; ssel = status_sel;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c;
    logic s0, s1, s2;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6 reset busy", busy, 0);
    chk("R6 reset suspended", suspended, 0);
    chk("R6 reset status", status, 0);
    rd(3, a, s0);
    chk("R10 reset status_sel", s0, 0);

    // table-driven erase runs
    foreach (VEC[v]) begin
      logic [31:0] sel, prot;
      int n;
      sel = VEC[v][63:32]; prot = VEC[v][31:0];
      prot_mask = prot;
      n = $countones(sel & ~prot);
      for (int s = 0; s < N_SECT; s++) if (sel[s]) send(2'd1, s);
      ticks(WIN - 1);
      chk("R1 window still open", status[3], 0);
      chk("R1 busy in window", busy, 1);
      ticks(1);
      chk("R6 erase phase bit", status[3], 1);
      k = 0;
      while (busy && !status[5] && k < 300) begin ticks(1); k++; end
      if (n == 0) begin
        chk("R11 all protected busy time", k, AP);
        chk("R11 idle after all protected", busy, 0);
      end else if (n * ER <= LIM) begin
        chk("R11 erase time", k, n * ER);
        chk("R11 idle after erase", busy, 0);
      end else begin
        chk("R12 limit tick", k, LIM);
        chk("R12 fail bit", status[5], 1);
        chk("R7 fail poll bit", status[7], 0);
        send(2'd1, 0);
        chk("R12 fail held on sector erase", status[5], 1);
        send(2'd0, 0);
        chk("R12 reset leaves fail", busy, 0);
      end
    end
    prot_mask = '0;

    // restart of window, suspend at sector boundary, toggles
    send(2'd1, 3);
    ticks(30);
    send(2'd1, 4);
    send(2'd1, 5);
    ticks(WIN - 1);
    chk("R1 restarted window open", status[3], 0);
    rd(7, a, s0);
    rd(7, b, s1);
    chk("R8 bit6 toggles in window", b[6], a[6] ^ 1'b1);
    ticks(1);
    chk("R1 erase started", status[3], 1);
    ticks(3);
    send(2'd0, 0);
    chk("R13 other ignored in erase", busy, 1);
    send(2'd1, 9);
    send(2'd2, 0);
    chk("R4 not yet suspended", suspended, 0);
    ticks(6);
    chk("R4 still running", suspended, 0);
    ticks(1);
    chk("R4 suspended at boundary", suspended, 1);
    chk("R7 poll bit suspended", status[7], 1);
    chk("R6 phase bit suspended", status[3], 1);
    ticks(30);
    chk("R4 suspension holds", suspended, 1);
    rd(3, a, s0);
    rd(3, b, s1);
    chk("R10 selected read status", s0, 1);
    chk("R9 bit2 toggles suspended", b[2], a[2] ^ 1'b1);
    chk("R8 bit6 steady suspended", b[6], a[6]);
    rd(9, c, s2);
    chk("R13 ignored sector not selected", s2, 0);
    rd(3, c, s2);
    chk("R9 unselected read no toggle", c[2], a[2]);
    send(2'd0, 0);
    chk("R13 other ignored in suspend", suspended, 1);
    send(2'd3, 0);
    chk("R5 resume", suspended, 0);
    chk("R5 busy after resume", busy, 1);
    send(2'd3, 0);
    chk("R5 repeated resume ignored", suspended, 0);
    rd(4, a, s0);
    rd(4, b, s1);
    chk("R9 bit2 toggles erasing", b[2], a[2] ^ 1'b1);
    chk("R8 bit6 toggles erasing", b[6], a[6] ^ 1'b1);
    chk("R7 poll bit erasing", b[7], 0);
    ticks(4);
    send(2'd2, 0);
    ticks(6);
    chk("R5 later suspend accepted", suspended, 1);
    send(2'd3, 0);
    ticks(ER - 1);
    chk("R4 progress kept busy", busy, 1);
    ticks(1);
    chk("R4 progress kept done", busy, 0);

    // suspend during window
    send(2'd1, 1);
    ticks(5);
    send(2'd2, 0);
    chk("R3 suspend in window", suspended, 1);
    chk("R6 phase bit after window suspend", status[3], 1);
    ticks(60);
    chk("R3 window suspend holds", suspended, 1);
    send(2'd3, 0);
    chk("R3 resume starts erase", suspended, 0);
    ticks(ER - 1);
    chk("R3 erasing", busy, 1);
    ticks(1);
    chk("R3 erase done", busy, 0);

    // abort window
    send(2'd1, 2);
    ticks(5);
    send(2'd3, 0);
    chk("R2 abort clears busy", busy, 0);
    ticks(60);
    chk("R2 no erase after abort", busy, 0);
    rd(2, a, s0);
    chk("R2 array reads after abort", s0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule